// File: doc/BRIEF.md
# Interleaved Two-Bank DRAM Controller

This controller connects an asynchronous 68000-style bus master and a periodic video fetcher to a DRAM array built as two byte-wide banks. Each bank has its own column strobe and both share one row strobe. Address bit 0 picks the bank, so neighbouring bytes sit in opposite banks. A word access strobes both banks in the same cycle. The multiplexed row and column address therefore comes from byte-address bits 1 upward. The whole controller runs on one base clock at twice the CPU clock, and every strobe edge falls on a base-clock edge.

A memory cycle always lasts four base clocks: row, column, hold and precharge. The next cycle can be granted on the idle clock after precharge. At each idle slot, a waiting video fetch wins over an owed refresh, and an owed refresh wins over the CPU. A CPU cycle starts when the address strobe is low with R/W sampled. The data strobe plays no part, so writes start as early as reads. Write enable falls together with the row strobe, so the DRAM latches write data on the falling column strobe. Refresh is RAS-only and steps an internal row counter. An interval timer requests it, and after reset a fixed burst of refresh cycles runs before any CPU access is accepted.

Top module: `dram_ilv_ctrl`

## Requirements
- R1: While reset is asserted and in the idle state that follows it, `dram_ras_n`, both bits of `dram_cas_n`, `dram_we_n` and `cpu_dtack_n` are all high and `vid_ack` is low.
- R2: For a cycle with word address W (byte address bits 1 up, or `vid_addr`), `dram_addr` carries W's upper MUX_W bits during the row clock and W's lower MUX_W bits during the two column clocks.
- R3: For a CPU byte access, only `dram_cas_n[0]` falls when address bit 0 is 0, and only `dram_cas_n[1]` falls when it is 1. For a CPU word access, both fall. The column strobes are low for exactly two base clocks.
- R4: In a CPU write (`cpu_rw`=0), `dram_we_n` is low for the same three clocks as `dram_ras_n`, so it falls one clock before the column strobe. It stays high in reads, video cycles and refresh cycles.
- R5: If an idle controller with nothing else pending samples the address strobe low, it lowers `dram_ras_n` after that edge, and `cpu_dtack_n` goes low four base clocks after the strobe was driven.
- R6: `cpu_dtack_n` returns high one base clock after the address strobe is seen high. While the strobe stays low after an acknowledge, no new CPU cycle starts.
- R7: A refresh cycle holds `dram_ras_n` low for three clocks with both column strobes high. Its row address comes from a counter that advances by one per refresh and wraps after 2^MUX_W rows, where MUX_W is 8, or 9 with deep devices.
- R8: The refresh timer raises one request every REF_INTERVAL base clocks (default 40).
- R9: After reset, INIT_REFRESH (default 8) refresh cycles complete before the first CPU cycle starts.
- R10: At an idle slot, a video request is served before an owed refresh, and an owed refresh is served before the CPU. A colliding CPU access sees `cpu_dtack_n` held off until it gets its own cycle.
- R11: A video cycle lowers both column strobes, and `vid_ack` is high for exactly the one precharge clock of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, twice the CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_as_n | input | 1 | CPU address strobe, active low |
| cpu_rw | input | 1 | CPU direction: 1 read, 0 write |
| cpu_word | input | 1 | 1 for a 16-bit access, 0 for a byte |
| cpu_addr | input | 2*MUX_W+1 | CPU byte address; bit 0 selects the bank |
| vid_req | input | 1 | Video fetch request, held until acknowledged |
| vid_addr | input | 2*MUX_W | Video word address |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe shared by both banks |
| dram_cas_n | output | 2 | Column strobes, bit 0 even bank, bit 1 odd bank |
| dram_we_n | output | 1 | DRAM write enable |
| cpu_dtack_n | output | 1 | Data acknowledge to the CPU |
| vid_ack | output | 1 | One-clock acknowledge of a finished video fetch |

## Verification
A granted cycle drives its row strobe and row address in the first clock after the granting edge. Column address and strobes follow one clock later, and the acknowledge (CPU or video) appears in the fourth clock. DTACK clears one clock after the address strobe is seen high. The bench keeps a behavioural model of these phase counts, the timer and the arbitration order, and updates it on the same rising edge as the design. It then compares every output on the falling edge, where the design has settled and the inputs have not yet changed. Latency checks count falling edges from the edge on which the stimulus was driven. The expected 4 clocks (free controller) or at least 9 (behind a video fetch) follow from that same phase count.

// File: rtl/dram_ilv_pkg.sv
package dram_ilv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROW,
    PH_COL,
    PH_HOLD,
    PH_PRE
  } phase_t;

  typedef enum logic [1:0] {
    OWN_CPU,
    OWN_VID,
    OWN_REF
  } owner_t;

  // Active-high bank enables: bit 0 even bank, bit 1 odd bank.
  function automatic logic [1:0] bank_strobes(input logic word, input logic a0);
    if (word) return 2'b11;
    return a0 ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/dram_ilv_refresh.sv
module dram_ilv_refresh #(
  parameter int MUX_W        = 8,
  parameter int REF_INTERVAL = 40,
  parameter int INIT_REFRESH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_take,
  output logic             ref_req,
  output logic [MUX_W-1:0] ref_row,
  output logic             init_done
);
  localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam int IW = $clog2(INIT_REFRESH + 1);

  logic [TW-1:0] tmr;
  logic [IW-1:0] init_left;
  logic          pend;
  logic          tick;

  assign tick      = (tmr == TW'(REF_INTERVAL - 1));
  assign init_done = (init_left == '0);
  assign ref_req   = pend | ~init_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr       <= '0;
      pend      <= 1'b0;
      init_left <= IW'(INIT_REFRESH);
      ref_row   <= '0;
    end else begin
      tmr  <= tick ? '0 : tmr + 1'b1;
      pend <= tick | (pend & ~(ref_take & init_done));
      if (ref_take) begin
        ref_row <= ref_row + 1'b1;
        if (!init_done) init_left <= init_left - 1'b1;
      end
    end
  end

  // R8: a timer tick is never followed by another on the next clock
  a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && REF_INTERVAL > 1) |=> !tick);

endmodule

// File: rtl/dram_ilv_arb.sv
module dram_ilv_arb (
  input  logic idle,
  input  logic vid_req,
  input  logic ref_req,
  input  logic cpu_as_n,
  input  logic cpu_armed,
  input  logic init_done,
  output logic gnt_vid,
  output logic gnt_ref,
  output logic gnt_cpu
);
  logic cpu_want;

  assign cpu_want = ~cpu_as_n & cpu_armed & init_done;

  always_comb begin
    gnt_vid = 1'b0;
    gnt_ref = 1'b0;
    gnt_cpu = 1'b0;
    if (idle) begin
      if (vid_req)       gnt_vid = 1'b1;
      else if (ref_req)  gnt_ref = 1'b1;
      else if (cpu_want) gnt_cpu = 1'b1;
    end
  end

endmodule

// File: rtl/dram_ilv_seq.sv
module dram_ilv_seq
  import dram_ilv_pkg::*;
#(
  parameter int MUX_W = 8,
  localparam int WADDR_W = 2 * MUX_W,
  localparam int BADDR_W = WADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gnt_vid,
  input  logic               gnt_ref,
  input  logic               gnt_cpu,
  input  logic               vid_req,
  input  logic               init_done,
  input  logic               cpu_as_n,
  input  logic               cpu_rw,
  input  logic               cpu_word,
  input  logic [BADDR_W-1:0] cpu_addr,
  input  logic [WADDR_W-1:0] vid_addr,
  input  logic [MUX_W-1:0]   ref_row,
  output logic               idle,
  output logic               cpu_armed,
  output logic [MUX_W-1:0]   dram_addr,
  output logic               dram_ras_n,
  output logic [1:0]         dram_cas_n,
  output logic               dram_we_n,
  output logic               cpu_dtack_n,
  output logic               vid_ack
);
  function automatic logic [MUX_W-1:0] row_part(input logic [WADDR_W-1:0] w);
    return w[WADDR_W-1:MUX_W];
  endfunction

  function automatic logic [MUX_W-1:0] col_part(input logic [WADDR_W-1:0] w);
    return w[MUX_W-1:0];
  endfunction

  phase_t           state;
  owner_t           owner;
  logic [MUX_W-1:0] lat_row, lat_col;
  logic [1:0]       lat_banks;
  logic             lat_wr;
  logic             lat_word;
  logic             dq;
  logic [WADDR_W-1:0] cpu_waddr;

  logic ras_active, cas_active, cpu_row_clk;

  assign cpu_waddr   = cpu_addr[BADDR_W-1:1];
  assign ras_active  = (state == PH_ROW) || (state == PH_COL) || (state == PH_HOLD);
  assign cas_active  = (state == PH_COL) || (state == PH_HOLD);
  assign cpu_row_clk = (state == PH_ROW) && (owner == OWN_CPU);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_IDLE;
      owner     <= OWN_CPU;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_banks <= 2'b00;
      lat_wr    <= 1'b0;
      lat_word  <= 1'b0;
      dq        <= 1'b0;
      cpu_armed <= 1'b0;
    end else begin
      if (cpu_as_n)     cpu_armed <= 1'b1;
      else if (gnt_cpu) cpu_armed <= 1'b0;

      if (cpu_as_n) dq <= 1'b0;
      else if (state == PH_HOLD && owner == OWN_CPU) dq <= 1'b1;

      unique case (state)
        PH_IDLE: begin
          if (gnt_vid) begin
            state     <= PH_ROW;
            owner     <= OWN_VID;
            lat_row   <= row_part(vid_addr);
            lat_col   <= col_part(vid_addr);
            lat_banks <= 2'b11;
            lat_wr    <= 1'b0;
            lat_word  <= 1'b1;
          end else if (gnt_ref) begin
            state     <= PH_ROW;
            owner     <= OWN_REF;
            lat_row   <= ref_row;
            lat_col   <= '0;
            lat_banks <= 2'b00;
            lat_wr    <= 1'b0;
            lat_word  <= 1'b0;
          end else if (gnt_cpu) begin
            state     <= PH_ROW;
            owner     <= OWN_CPU;
            lat_row   <= row_part(cpu_waddr);
            lat_col   <= col_part(cpu_waddr);
            lat_banks <= bank_strobes(cpu_word, cpu_addr[0]);
            lat_wr    <= ~cpu_rw;
            lat_word  <= cpu_word;
          end
        end
        PH_ROW:  state <= PH_COL;
        PH_COL:  state <= PH_HOLD;
        PH_HOLD: state <= PH_PRE;
        PH_PRE:  state <= PH_IDLE;
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign idle        = (state == PH_IDLE);
  assign dram_ras_n  = ~ras_active;
  assign dram_cas_n  = ~(cas_active ? lat_banks : 2'b00);
  assign dram_we_n   = ~(ras_active & lat_wr);
  assign dram_addr   = cas_active ? lat_col : lat_row;
  assign cpu_dtack_n = ~dq;
  assign vid_ack     = (state == PH_PRE) && (owner == OWN_VID);

  // R1: idle means every strobe is inactive
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (dram_ras_n && dram_cas_n == 2'b11 && dram_we_n));

  // R4: write enable is already low on the clock before a column strobe falls
  a_r4_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas_n != 2'b11 && $past(dram_cas_n) == 2'b11 && !dram_we_n) |-> $past(!dram_we_n));

  // R3: a CPU byte access strobes one bank only
  a_r3_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_CPU && !lat_word && cas_active) |-> $countones(~dram_cas_n) == 1);

  // R7: refresh cycles never strobe a column
  a_r7_ras_only: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_REF) |-> dram_cas_n == 2'b11);

  // R6: acknowledge drops one clock after the address strobe goes high
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_as_n |=> cpu_dtack_n);

  // R10: a CPU cycle never starts while video was asking
  a_r10_video_first: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_row_clk |-> $past(!vid_req));

  // R9: a CPU cycle only starts once the start-up refreshes are done
  a_r9_init_first: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_row_clk |-> $past(init_done));

endmodule

// File: rtl/dram_ilv_ctrl.sv
module dram_ilv_ctrl #(
  parameter bit DEEP_ROWS    = 1'b0,
  parameter int REF_INTERVAL = 40,
  parameter int INIT_REFRESH = 8,
  localparam int MUX_W   = DEEP_ROWS ? 9 : 8,
  localparam int WADDR_W = 2 * MUX_W,
  localparam int BADDR_W = WADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_as_n,
  input  logic               cpu_rw,
  input  logic               cpu_word,
  input  logic [BADDR_W-1:0] cpu_addr,
  input  logic               vid_req,
  input  logic [WADDR_W-1:0] vid_addr,
  output logic [MUX_W-1:0]   dram_addr,
  output logic               dram_ras_n,
  output logic [1:0]         dram_cas_n,
  output logic               dram_we_n,
  output logic               cpu_dtack_n,
  output logic               vid_ack
);
  logic             idle, cpu_armed;
  logic             gnt_vid, gnt_ref, gnt_cpu;
  logic             ref_req, init_done;
  logic [MUX_W-1:0] ref_row;

  dram_ilv_refresh #(
    .MUX_W(MUX_W), .REF_INTERVAL(REF_INTERVAL), .INIT_REFRESH(INIT_REFRESH)
  ) u_refresh (
    .clk(clk), .rst_n(rst_n), .ref_take(gnt_ref),
    .ref_req(ref_req), .ref_row(ref_row), .init_done(init_done)
  );

  dram_ilv_arb u_arb (
    .idle(idle), .vid_req(vid_req), .ref_req(ref_req),
    .cpu_as_n(cpu_as_n), .cpu_armed(cpu_armed), .init_done(init_done),
    .gnt_vid(gnt_vid), .gnt_ref(gnt_ref), .gnt_cpu(gnt_cpu)
  );

  dram_ilv_seq #(.MUX_W(MUX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .gnt_vid(gnt_vid), .gnt_ref(gnt_ref), .gnt_cpu(gnt_cpu),
    .vid_req(vid_req), .init_done(init_done),
    .cpu_as_n(cpu_as_n), .cpu_rw(cpu_rw), .cpu_word(cpu_word),
    .cpu_addr(cpu_addr), .vid_addr(vid_addr), .ref_row(ref_row),
    .idle(idle), .cpu_armed(cpu_armed),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .cpu_dtack_n(cpu_dtack_n), .vid_ack(vid_ack)
  );

endmodule

// File: tb/dram_ilv_ctrl_tb.sv
module dram_ilv_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 8;
  localparam int IVL = 40;
  localparam int NINIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_as_n = 1'b1, cpu_rw = 1'b1, cpu_word = 1'b0;
  logic [2*MW:0] cpu_addr = '0;
  logic vid_req = 1'b0;
  logic [2*MW-1:0] vid_addr = '0;
  logic [MW-1:0] dram_addr;
  logic dram_ras_n, dram_we_n, cpu_dtack_n, vid_ack;
  logic [1:0] dram_cas_n;

  int total = 0, bad = 0, cycles = 0;
  bit cmp_on = 0;

  dram_ilv_ctrl #(.DEEP_ROWS(1'b0), .REF_INTERVAL(IVL), .INIT_REFRESH(NINIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_rw(cpu_rw),
    .cpu_word(cpu_word), .cpu_addr(cpu_addr), .vid_req(vid_req),
    .vid_addr(vid_addr), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .cpu_dtack_n(cpu_dtack_n), .vid_ack(vid_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int ph = 0, own = 0, mrow = 0, mcol = 0, mbanks = 0, mwr = 0;
  int init_left = NINIT, tcount = 0, pend = 0, armed = 0, dq = 0, rrow = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; own = 0; mrow = 0; mcol = 0; mbanks = 0; mwr = 0;
      init_left = NINIT; tcount = 0; pend = 0; armed = 0; dq = 0; rrow = 0;
    end else begin
      int tick, gref, gcpu, nph, wa;
      tick = (tcount == IVL - 1);
      gref = 0; gcpu = 0; nph = ph;
      if (ph == 0) begin
        if (vid_req) begin
          nph = 1; own = 1; mrow = vid_addr / 256; mcol = vid_addr % 256;
          mbanks = 3; mwr = 0;
        end else if (pend || init_left > 0) begin
          gref = 1; nph = 1; own = 2; mrow = rrow; mcol = 0; mbanks = 0; mwr = 0;
        end else if (!cpu_as_n && armed) begin
          gcpu = 1; nph = 1; own = 0; wa = cpu_addr / 2;
          mrow = wa / 256; mcol = wa % 256;
          mbanks = cpu_word ? 3 : (cpu_addr[0] ? 2 : 1);
          mwr = !cpu_rw;
        end
      end else nph = (ph == 4) ? 0 : ph + 1;
      if (cpu_as_n) dq = 0; else if (ph == 3 && own == 0) dq = 1;
      if (cpu_as_n) armed = 1; else if (gcpu) armed = 0;
      pend = tick | (pend & !(gref && init_left == 0));
      if (gref) begin
        if (init_left > 0) init_left--;
        rrow = (rrow + 1) % (1 << MW);
      end
      tcount = tick ? 0 : tcount + 1;
      ph = nph;
    end
  end

  // every-clock comparison, away from the rising edge
  int run = 0, refcnt = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      int eras, ecas, ewe;
      eras = (ph >= 1 && ph <= 3) ? 0 : 1;
      ecas = (ph == 2 || ph == 3) ? (3 & ~mbanks) : 3;
      ewe  = (ph >= 1 && ph <= 3 && mwr) ? 0 : 1;
      chk(dram_ras_n == eras[0], own == 2 ? "R7 ras" : "R5 ras", dram_ras_n, eras);
      chk(dram_cas_n == ecas[1:0], own == 1 ? "R11 cas" : "R3 cas", dram_cas_n, ecas);
      chk(dram_we_n == ewe[0], "R4 we", dram_we_n, ewe);
      chk(cpu_dtack_n == !dq, "R6 dtack", cpu_dtack_n, !dq);
      chk(vid_ack == (ph == 4 && own == 1), "R11 ack", vid_ack, ph == 4 && own == 1);
      if (ph == 1) chk(dram_addr == mrow[MW-1:0], own == 2 ? "R7 row" : "R2 row", dram_addr, mrow);
      if (ph == 2 || ph == 3) chk(dram_addr == mcol[MW-1:0], "R2 col", dram_addr, mcol);
    end
    if (!dram_ras_n && dram_cas_n == 2'b11) run++; else run = 0;
    if (run == 3) refcnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cpu_access(input int addr, input bit rd, input bit word, output int lat);
    @(negedge clk);
    cpu_addr = addr[2*MW:0]; cpu_rw = rd; cpu_word = word; cpu_as_n = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (cpu_dtack_n && lat < 200);
    cpu_as_n = 1'b1;
    @(negedge clk);
    chk(cpu_dtack_n == 1'b1, "R6 release", cpu_dtack_n, 1);
  endtask

  initial begin
    int lat, idle_ok, r0, casseen;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n == 2'b11 && dram_we_n && cpu_dtack_n && !vid_ack,
        "R1 reset", {dram_ras_n, dram_cas_n, dram_we_n, cpu_dtack_n}, 5'b11111);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    chk(dram_ras_n == 1'b0 && dram_cas_n == 2'b11, "R9 refresh first", dram_ras_n, 0);

    // first CPU access must wait for the start-up refreshes
    cpu_access(17'h00246, 1, 0, lat);
    chk(refcnt >= NINIT, "R9 init count", refcnt, NINIT);

    // byte and word accesses in both banks, reads and writes
    for (int i = 0; i < 24; i++) begin
      int a;
      bit w;
      w = (i % 3 == 2);
      a = (i * 4099 + 77) % (1 << (2*MW+1));
      if (w) a = a & ~1;
      idle_ok = (ph == 0 && !pend && tcount < IVL - 8);
      cpu_access(a, i[0], w, lat);
      if (idle_ok) chk(lat == 4, "R5 latency", lat, 4);
      else chk(lat >= 4, "R5 latency", lat, 4);
    end

    // hold AS low after acknowledge: no second cycle, DTACK stays low
    @(negedge clk);
    cpu_addr = 17'h1ABCD; cpu_rw = 1'b0; cpu_word = 1'b0; cpu_as_n = 1'b0;
    do @(negedge clk); while (cpu_dtack_n);
    casseen = 0;
    repeat (12) begin
      @(negedge clk);
      if (dram_cas_n != 2'b11) casseen++;
      chk(cpu_dtack_n == 1'b0, "R6 hold", cpu_dtack_n, 0);
    end
    chk(casseen == 0, "R6 no restart", casseen, 0);
    cpu_as_n = 1'b1;
    @(negedge clk);
    chk(cpu_dtack_n == 1'b1, "R6 release", cpu_dtack_n, 1);

    // video and CPU collide: video goes first
    for (int k = 0; k < 6; k++) begin
      bit vdone;
      @(negedge clk);
      vid_addr = 16'(k * 7919 + 3); vid_req = 1'b1;
      cpu_addr = 17'(k * 513 + 1); cpu_rw = 1'b1; cpu_word = 1'b0; cpu_as_n = 1'b0;
      lat = 0; vdone = 0;
      do begin
        @(negedge clk); lat++;
        if (vid_ack) begin vid_req = 1'b0; vdone = 1; end
      end while (cpu_dtack_n && lat < 200);
      chk(vdone, "R11 ack seen", vdone, 1);
      chk(lat >= 9, "R10 cpu waits", lat, 9);
      cpu_as_n = 1'b1;
      @(negedge clk);
    end

    // refresh rate over a quiet window, also walks the row counter past wrap
    r0 = refcnt;
    repeat (4000) @(negedge clk);
    chk(refcnt - r0 >= 99 && refcnt - r0 <= 101, "R8 rate", refcnt - r0, 100);
    repeat (7000) @(negedge clk);
    chk(refcnt > (1 << MW), "R7 wrap reached", refcnt, 1 << MW);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule